// File: doc/BRIEF.md
# Rotating Register File Renamer

This block is a register file built for software-pipelined loops. Its register space is split in two. A low static region maps each logical specifier directly to the physical register with the same index. A high rotating region is addressed relative to a rotation base that moves once per loop iteration. Because of this, every iteration works on a fresh set of physical registers without any change to the code. A value produced under one logical name in one iteration is found under the next higher name in the following iteration.

The block has one synchronous write port and two combinational read ports, and all three apply the same specifier-to-physical mapping. A loop-closing branch pulse does two things. It steps the rotation base down by one. It also shifts a bank of one-bit stage predicates up by one position, loading the lowest predicate from a stage-enable input. Software uses these predicates to switch pipeline stages on one after another during the prolog, and off one after another during the epilog.

Top module: `rot_regfile`

## Requirements
- R1: While reset is asserted and after it is released, the rotation base is 0, all predicates are 0 and every register reads as 0.
- R2: A specifier below NUM_STATIC (default 8) selects the physical register of the same index, whatever the rotation base.
- R3: A specifier s of NUM_STATIC or above selects physical register NUM_STATIC + ((s - NUM_STATIC + base) mod (NUM_REGS - NUM_STATIC)); the defaults give modulo 24 plus 8.
- R4: Each cycle with loop_br_i high lowers the base by one, and the base wraps from 0 to NUM_REGS - NUM_STATIC - 1 (23). In a cycle with loop_br_i low the base holds. The base is visible on rot_base_o.
- R5: A value written to rotating specifier k is read through specifier k+1 after one rotation. Specifier NUM_REGS-1 (31) continues at NUM_STATIC (8).
- R6: On a loop_br_i pulse, pred_o[0] takes stage_en_i and pred_o[i] takes the old pred_o[i-1]. Without a pulse, pred_o holds.
- R7: When a write and a loop_br_i pulse fall in the same cycle, the write uses the base from before the rotation.
- R8: Both read ports decode independently with the same mapping and return the stored data in the same cycle.
- R9: With we_i low, no register changes, whatever the values on wr_spec_i and wr_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| wr_spec_i | input | IDX_W (5) | Logical write specifier |
| wr_data_i | input | DATA_W (32) | Write data |
| rd0_spec_i | input | IDX_W (5) | Logical specifier, read port 0 |
| rd0_data_o | output | DATA_W (32) | Read data, port 0 |
| rd1_spec_i | input | IDX_W (5) | Logical specifier, read port 1 |
| rd1_data_o | output | DATA_W (32) | Read data, port 1 |
| loop_br_i | input | 1 | Loop-closing branch pulse; rotates base and predicates |
| stage_en_i | input | 1 | Value loaded into predicate 0 on rotation |
| rot_base_o | output | BASE_W (5) | Current rotation base |
| pred_o | output | NUM_PRED (8) | Rotating stage predicates |

## Verification
On every cycle, the assertions check the decrement-and-wrap of the base, its hold when no pulse arrives, and its range. They also check the predicate shift and hold. Across each pair of cycles, they check that a value read back under the same name, or under the next rotating name after a pulse, matches what was written, and this includes a write coinciding with the pulse. The bench's reference model covers what needs long histories: values that stay put in the static region across many rotations, the full 24-step wrap of the base, the 31-to-8 name wrap, the lack of effect from disabled writes, and random mixes of writes, reads and pulses on both read ports.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned DEF_DATA_W     = 32;
  localparam int unsigned DEF_NUM_REGS   = 32;
  localparam int unsigned DEF_NUM_STATIC = 8;
  localparam int unsigned DEF_NUM_PRED   = 8;
  localparam int unsigned NUM_PORTS      = 3;  // write, read0, read1
endpackage

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned NUM_STATIC = 8,
  parameter int unsigned IDX_W      = $clog2(NUM_REGS),
  parameter int unsigned BASE_W     = $clog2(NUM_REGS - NUM_STATIC)
) (
  input  logic [IDX_W-1:0]  spec_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [IDX_W-1:0]  phys_o
);
  localparam int unsigned ROT = NUM_REGS - NUM_STATIC;

  logic [IDX_W:0] off;
  logic [IDX_W:0] sum;
  logic [IDX_W:0] wrapped;

  always_comb begin
    off     = {1'b0, spec_i} - (IDX_W+1)'(NUM_STATIC);
    sum     = off + (IDX_W+1)'(base_i);
    wrapped = (sum >= (IDX_W+1)'(ROT)) ? sum - (IDX_W+1)'(ROT) : sum;
    if (spec_i < IDX_W'(NUM_STATIC)) phys_o = spec_i;
    else                             phys_o = IDX_W'(NUM_STATIC) + wrapped[IDX_W-1:0];
  end
endmodule

// File: rtl/rrf_base.sv
module rrf_base #(
  parameter int unsigned ROT    = 24,
  parameter int unsigned BASE_W = $clog2(ROT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rot_i,
  output logic [BASE_W-1:0] base_o
);
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_q <= '0;
    else if (rot_i) base_q <= (base_q == '0) ? BASE_W'(ROT - 1) : base_q - 1'b1;
  end

  assign base_o = base_q;
endmodule

// File: rtl/rrf_pred.sv
module rrf_pred #(
  parameter int unsigned NUM_PRED = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rot_i,
  input  logic                stage_en_i,
  output logic [NUM_PRED-1:0] pred_o
);
  logic [NUM_PRED-1:0] pred_q;
  logic [NUM_PRED-1:0] pred_d;

  generate
    if (NUM_PRED == 1) begin : g_single
      assign pred_d = stage_en_i;
    end else begin : g_shift
      assign pred_d = {pred_q[NUM_PRED-2:0], stage_en_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pred_q <= '0;
    else if (rot_i) pred_q <= pred_d;
  end

  assign pred_o = pred_q;
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int unsigned DATA_W     = rrf_pkg::DEF_DATA_W,
  parameter int unsigned NUM_REGS   = rrf_pkg::DEF_NUM_REGS,
  parameter int unsigned NUM_STATIC = rrf_pkg::DEF_NUM_STATIC,
  parameter int unsigned NUM_PRED   = rrf_pkg::DEF_NUM_PRED,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS),
  localparam int unsigned ROT       = NUM_REGS - NUM_STATIC,
  localparam int unsigned BASE_W    = $clog2(ROT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    wr_spec_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [IDX_W-1:0]    rd0_spec_i,
  output logic [DATA_W-1:0]   rd0_data_o,
  input  logic [IDX_W-1:0]    rd1_spec_i,
  output logic [DATA_W-1:0]   rd1_data_o,
  input  logic                loop_br_i,
  input  logic                stage_en_i,
  output logic [BASE_W-1:0]   rot_base_o,
  output logic [NUM_PRED-1:0] pred_o
);
  localparam int unsigned NP = rrf_pkg::NUM_PORTS;

  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  spec_a [NP];
  logic [IDX_W-1:0]  phys_a [NP];
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  rrf_base #(.ROT(ROT), .BASE_W(BASE_W)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rot_i (loop_br_i),
    .base_o(base)
  );

  rrf_pred #(.NUM_PRED(NUM_PRED)) u_pred (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rot_i     (loop_br_i),
    .stage_en_i(stage_en_i),
    .pred_o    (pred_o)
  );

  assign spec_a[0] = wr_spec_i;
  assign spec_a[1] = rd0_spec_i;
  assign spec_a[2] = rd1_spec_i;

  generate
    for (genvar p = 0; p < NP; p++) begin : g_map
      rrf_map #(
        .NUM_REGS  (NUM_REGS),
        .NUM_STATIC(NUM_STATIC),
        .IDX_W     (IDX_W),
        .BASE_W    (BASE_W)
      ) u_map (
        .spec_i(spec_a[p]),
        .base_i(base),
        .phys_o(phys_a[p])
      );
    end
  endgenerate

  // write maps through the pre-rotation base
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[phys_a[0]] <= wr_data_i;
    end
  end

  assign rd0_data_o = regs_q[phys_a[1]];
  assign rd1_data_o = regs_q[phys_a[2]];
  assign rot_base_o = base;
endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned NUM_STATIC = 8,
  parameter int unsigned NUM_PRED   = 8,
  parameter int unsigned IDX_W      = $clog2(NUM_REGS),
  parameter int unsigned BASE_W     = $clog2(NUM_REGS - NUM_STATIC)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [IDX_W-1:0]    wr_spec_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [IDX_W-1:0]    rd0_spec_i,
  input logic [DATA_W-1:0]   rd0_data_o,
  input logic [IDX_W-1:0]    rd1_spec_i,
  input logic [DATA_W-1:0]   rd1_data_o,
  input logic                loop_br_i,
  input logic                stage_en_i,
  input logic [BASE_W-1:0]   rot_base_o,
  input logic [NUM_PRED-1:0] pred_o
);
  localparam int unsigned ROT = NUM_REGS - NUM_STATIC;

  logic [IDX_W-1:0]  wr_next;
  logic [BASE_W-1:0] base_dec;
  logic [NUM_PRED:0] pred_ext;
  logic              wr_rot;

  assign wr_rot   = wr_spec_i >= IDX_W'(NUM_STATIC);
  assign wr_next  = (wr_spec_i == IDX_W'(NUM_REGS - 1)) ? IDX_W'(NUM_STATIC) : wr_spec_i + 1'b1;
  assign base_dec = (rot_base_o == '0) ? BASE_W'(ROT - 1) : rot_base_o - 1'b1;
  assign pred_ext = {pred_o, stage_en_i};

  a_r4_base_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_br_i |=> rot_base_o == $past(base_dec));

  a_r4_base_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_br_i |=> $stable(rot_base_o));

  a_r4_base_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_base_o < BASE_W'(ROT));

  a_r6_pred_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_br_i |=> pred_o == $past(pred_ext[NUM_PRED-1:0]));

  a_r6_pred_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_br_i |=> $stable(pred_o));

  // R3: same name, no rotation, data comes back
  a_r3_same_name: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && !$past(loop_br_i) && rd0_spec_i == $past(wr_spec_i))
      |-> rd0_data_o == $past(wr_data_i));

  // R5 and R7: rotating write (even with a coincident pulse) appears at next name
  a_r5_next_name: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(loop_br_i) && $past(wr_rot) && rd1_spec_i == $past(wr_next))
      |-> rd1_data_o == $past(wr_data_i));

  // R2: static write survives a rotation under the same name
  a_r2_static_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && !$past(wr_rot) && rd1_spec_i == $past(wr_spec_i))
      |-> rd1_data_o == $past(wr_data_i));
endmodule

bind rot_regfile rot_regfile_chk #(
  .DATA_W    (DATA_W),
  .NUM_REGS  (NUM_REGS),
  .NUM_STATIC(NUM_STATIC),
  .NUM_PRED  (NUM_PRED),
  .IDX_W     (IDX_W),
  .BASE_W    (BASE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .wr_spec_i (wr_spec_i),
  .wr_data_i (wr_data_i),
  .rd0_spec_i(rd0_spec_i),
  .rd0_data_o(rd0_data_o),
  .rd1_spec_i(rd1_spec_i),
  .rd1_data_o(rd1_data_o),
  .loop_br_i (loop_br_i),
  .stage_en_i(stage_en_i),
  .rot_base_o(rot_base_o),
  .pred_o    (pred_o)
);

// File: tb/rot_regfile_tb.sv
`timescale 1ns/1ps
module rot_regfile_tb;
  localparam int NR = 32;
  localparam int NS = 8;
  localparam int ROT = NR - NS;
  localparam int NPR = 8;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        we_i = 0;
  logic [4:0]  wr_spec_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [4:0]  rd0_spec_i = 0;
  logic [31:0] rd0_data_o;
  logic [4:0]  rd1_spec_i = 0;
  logic [31:0] rd1_data_o;
  logic        loop_br_i = 0;
  logic        stage_en_i = 0;
  logic [4:0]  rot_base_o;
  logic [7:0]  pred_o;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_regs [NR];
  int          m_base;
  logic [7:0]  m_pred;

  always #2 clk_i = ~clk_i;

  rot_regfile u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wr_spec_i(wr_spec_i),
    .wr_data_i(wr_data_i), .rd0_spec_i(rd0_spec_i), .rd0_data_o(rd0_data_o),
    .rd1_spec_i(rd1_spec_i), .rd1_data_o(rd1_data_o), .loop_br_i(loop_br_i),
    .stage_en_i(stage_en_i), .rot_base_o(rot_base_o), .pred_o(pred_o)
  );

  function automatic int phys(input int spec, input int base);
    if (spec < NS) return spec;
    return NS + ((spec - NS + base) % ROT);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, check, clock, update model
  task automatic step(input bit we, input int ws, input logic [31:0] wd,
                      input int r0, input int r1, input bit br, input bit se,
                      input string tag);
    logic [31:0] e0, e1;
    we_i = we; wr_spec_i = 5'(ws); wr_data_i = wd;
    rd0_spec_i = 5'(r0); rd1_spec_i = 5'(r1);
    loop_br_i = br; stage_en_i = se;
    #1;
    e0 = m_regs[phys(r0, m_base)];
    e1 = m_regs[phys(r1, m_base)];
    chk(rd0_data_o === e0, tag, rd0_data_o, e0);
    chk(rd1_data_o === e1, "R8", rd1_data_o, e1);
    chk(rot_base_o === 5'(m_base), "R4", 32'(rot_base_o), 32'(m_base));
    chk(pred_o === m_pred, "R6", 32'(pred_o), 32'(m_pred));
    @(posedge clk_i);
    if (we) m_regs[phys(ws, m_base)] = wd;   // R7: pre-rotation base
    if (br) begin
      m_base = (m_base == 0) ? ROT - 1 : m_base - 1;
      m_pred = {m_pred[NPR-2:0], se};
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) m_regs[i] = '0;
    m_base = 0;
    m_pred = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(rot_base_o === 5'd0, "R1", 32'(rot_base_o), 0);
    chk(pred_o === 8'd0, "R1", 32'(pred_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    rd0_spec_i = 5'd20; rd1_spec_i = 5'd3;
    #1;
    chk(rd0_data_o === 32'd0, "R1", rd0_data_o, 0);
    chk(rd1_data_o === 32'd0, "R1", rd1_data_o, 0);
    @(negedge clk_i);

    // R5: name k becomes k+1 after one rotation
    step(1, 12, 32'hA5A5_0012, 0, 0, 0, 1, "R3");
    step(0, 0, 0, 12, 12, 1, 1, "R3");
    step(0, 0, 0, 13, 12, 0, 0, "R5");
    // R5: 31 wraps to 8
    step(1, 31, 32'hC0DE_0031, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 31, 0, 1, 1, "R3");
    step(0, 0, 0, 8, 31, 0, 0, "R5");
    // R7: write and rotate together
    step(1, 10, 32'hBEEF_0010, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 11, 10, 0, 0, "R7");
    // R9: disabled write
    step(0, 15, 32'hDEAD_0015, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 15, 15, 0, 0, "R9");
    // R2: static name stable across rotations
    step(1, 3, 32'h5757_0003, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 3, 3, 1, i[0], "R2");
    step(0, 0, 0, 3, 5, 0, 0, "R2");
    // R4: full wrap of the base
    for (int i = 0; i < ROT + 2; i++) step(0, 0, 0, 9, 30, 1, (i % 3) == 0, "R4");
    // R6: predicate fill then drain
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 1, "R6");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, 0, "R6");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r0;
      r0 = $urandom_range(NR - 1);
      step(($urandom_range(3) != 0), $urandom_range(NR - 1), $urandom(),
           r0, $urandom_range(NR - 1), ($urandom_range(3) == 0), $urandom_range(1),
           (r0 < NS) ? "R2" : "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule